// File: doc/BRIEF.md
# Block Reset Control Register with Load, Release and Hold Aliases

This block keeps one state bit for each of six downstream sub-blocks on a simple memory-mapped register bus. A bit value of 1 lets its sub-block run. A bit value of 0 holds that sub-block in reset. The block drives these bits out as registered active-low reset lines, and one bit drives two lines.

Software reaches the same storage through four word addresses:
- A plain load alias writes every bit.
- A release alias takes out of reset only the bits written as 1.
- A hold alias puts into reset only the bits written as 1.
- A fourth alias does nothing on a write.

With the release and hold aliases, software can change one sub-block without a read-modify-write and without touching the other sub-blocks.

Top module: `rstctl_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every state bit is 0 and every `rst_n_o` line is low (all sub-blocks held in reset).
- R2: A write to the base address (0x8060, alias 0) loads state bits 5:0 from `wr_data_i[5:0]`. A 1 releases the sub-block and a 0 holds it in reset.
- R3: A write to base+4 (alias 1) sets each state bit whose data bit is 1. State bits whose data bit is 0 keep their value.
- R4: A write to base+8 (alias 2) clears each state bit whose data bit is 1. State bits whose data bit is 0 keep their value.
- R5: A write to base+12 (alias 3) changes no state bit and no reset line.
- R6: While `rd_en_i` is high and the address is any of the four aliases, `rd_data_o` shows the state bits in bits 5:0, in the same cycle. Bits 31:6 always read 0, and writes to them have no effect.
- R7: The reset lines map from the state bits as follows:
  - `rst_n_o[4:0]` follow state bits 4:0 (host interface, request, read path, write path, address translation).
  - `rst_n_o[5]` (page table) also follows state bit 4.
  - `rst_n_o[6]` (clock/peripheral bridge) follows state bit 5.
  - Each line changes on the clock edge after the edge that updates its state bit.
- R8: When a read and a write hit the block in the same cycle, the read returns the state from before that write.
- R9: Writes to an address outside base..base+15, or with `addr_i[1:0]` not zero, change nothing. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 32 | Byte address of the bus access |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, combinational, valid while `rd_en_i` is high |
| rst_n_o | output | 7 | Active-low reset lines to the sub-blocks |

## Verification
The hardest case to reach from the ports is a read and a write landing on the block in the same cycle, particularly a hold-alias write. Ordinary tasks issue them one at a time, so the bench has a combined task that raises both strobes in one cycle. That task queues the pre-write value before updating its model. The bench also targets corners that other tests would miss:
- Release and hold writes whose data has ones in bits 31:6 and on bits already in the wanted state, to show the upper bits stay 0.
- A write with a misaligned address and a write to the next word past the aliases.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_BITS = 6;
    localparam int NUM_OUTS = 7;
    localparam int FAN_BIT  = 4;   // state bit that drives two lines

    typedef enum logic [1:0] {
        ALIAS_LOAD = 2'd0,
        ALIAS_REL  = 2'd1,
        ALIAS_HOLD = 2'd2,
        ALIAS_NOP  = 2'd3
    } alias_e;

    typedef struct packed {
        logic   hit;
        alias_e kind;
    } dec_t;

    typedef logic [NUM_BITS-1:0] state_t;

    // Which state bit drives reset line idx.
    function automatic int out_src(int idx);
        if (idx < NUM_BITS - 1) return idx;
        if (idx == NUM_BITS - 1) return FAN_BIT;
        return NUM_BITS - 1;
    endfunction

    function automatic state_t next_state(alias_e kind, state_t cur, state_t wd);
        case (kind)
            ALIAS_LOAD: return wd;
            ALIAS_REL:  return cur | wd;
            ALIAS_HOLD: return cur & ~wd;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode
    import rstctl_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0000_8060
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    localparam int WIN_LSB = 4;   // four 32-bit words

    logic [ADDR_W-1:0] base_c;
    assign base_c = BASE_ADDR[ADDR_W-1:0];

    always_comb begin
        dec_o.hit  = (addr_i[ADDR_W-1:WIN_LSB] == base_c[ADDR_W-1:WIN_LSB])
                     && (addr_i[1:0] == 2'b00);
        dec_o.kind = alias_e'(addr_i[3:2]);
    end
endmodule

// File: rtl/rstctl_state.sv
module rstctl_state
    import rstctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en_i,
    input  dec_t   dec_i,
    input  state_t wdata_i,
    output state_t state_o
);
    state_t state_q;
    logic   wr_hit;

    assign wr_hit = wr_en_i && dec_i.hit;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else if (wr_hit)
            state_q <= next_state(dec_i.kind, state_q, wdata_i);
    end

    assign state_o = state_q;

    // R2
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && dec_i.kind == ALIAS_LOAD) |=> state_q == $past(wdata_i));
    // R3
    assert_release_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && dec_i.kind == ALIAS_REL) |=>
            ((state_q & $past(wdata_i)) == $past(wdata_i)) &&
            ((state_q & ~$past(wdata_i)) == ($past(state_q) & ~$past(wdata_i))));
    // R4
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && dec_i.kind == ALIAS_HOLD) |=>
            ((state_q & $past(wdata_i)) == '0) &&
            ((state_q & ~$past(wdata_i)) == ($past(state_q) & ~$past(wdata_i))));
    // R5, R9
    assert_nop_R5: assert property (@(posedge clk) disable iff (rst)
        !(wr_hit && dec_i.kind != ALIAS_NOP) |=> $stable(state_q));
endmodule

// File: rtl/rstctl_outs.sv
module rstctl_outs
    import rstctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  state_t              state_i,
    output logic [NUM_OUTS-1:0] rst_n_o
);
    logic [NUM_OUTS-1:0] rst_n_q;

    for (genvar g = 0; g < NUM_OUTS; g++) begin : g_line
        localparam int SRC = out_src(g);
        always_ff @(posedge clk) begin
            if (rst) rst_n_q[g] <= 1'b0;
            else     rst_n_q[g] <= state_i[SRC];
        end
    end

    assign rst_n_o = rst_n_q;

    // R7: the two lines fed by the shared bit never disagree
    assert_fanout_R7: assert property (@(posedge clk) disable iff (rst)
        rst_n_q[FAN_BIT] == rst_n_q[NUM_BITS-1]);
    // R7: one-edge lag behind the state
    assert_lag_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rst_n_q[NUM_OUTS-1] == $past(state_i[NUM_BITS-1]));
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0000_8060
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_en_i,
    input  logic [REG_W-1:0]    wr_data_i,
    input  logic                rd_en_i,
    output logic [REG_W-1:0]    rd_data_o,
    output logic [NUM_OUTS-1:0] rst_n_o
);
    dec_t   dec;
    state_t state;
    logic   unused_hi;

    assign unused_hi = ^wr_data_i[REG_W-1:NUM_BITS];

    rstctl_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr_i (addr_i),
        .dec_o  (dec)
    );

    rstctl_state u_state (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en_i),
        .dec_i   (dec),
        .wdata_i (wr_data_i[NUM_BITS-1:0]),
        .state_o (state)
    );

    rstctl_outs u_outs (
        .clk     (clk),
        .rst     (rst),
        .state_i (state),
        .rst_n_o (rst_n_o)
    );

    assign rd_data_o = (rd_en_i && dec.hit)
                       ? {{(REG_W-NUM_BITS){1'b0}}, state} : '0;

    // R6
    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[REG_W-1:NUM_BITS] == '0);
    // R1
    assert_reset_lines_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rst_n_o == '0);
endmodule

// File: tb/rstctl_top_tb_top.sv
module rstctl_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [6:0]  rst_n;

    int checks = 0;
    int errors = 0;
    logic [5:0]  model = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [31:0] BASE = 32'h0000_8060;

    always #2.5 clk = ~clk;

    rstctl_top dut_i (
        .clk(clk), .rst(rst), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .rst_n_o(rst_n)
    );

    function automatic logic [6:0] lines(logic [5:0] m);
        return {m[5], m[4], m[4:0]};
    endfunction

    function automatic logic [5:0] apply(logic [31:0] a, logic [31:0] d, logic [5:0] m);
        if (a[31:4] != BASE[31:4] || a[1:0] != 2'b00) return m;
        case (a[3:2])
            2'd0: return d[5:0];
            2'd1: return m | d[5:0];
            2'd2: return m & ~d[5:0];
            default: return m;
        endcase
    endfunction

    function automatic logic [31:0] rd_exp(logic [31:0] a, logic [5:0] m);
        if (a[31:4] != BASE[31:4] || a[1:0] != 2'b00) return '0;
        return {26'd0, m};
    endfunction

    // monitor: compare reads at the falling edge
    always @(negedge clk) begin
        if (rd_en && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL %s: rd_data %h expected %h", t, rd_data, e);
            end
        end
    end

    task automatic do_wr(input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        addr = a; wr_data = d; wr_en = 1'b1;
        model = apply(a, d, model);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [31:0] a, input string t);
        @(posedge clk); #1;
        addr = a; rd_en = 1'b1;
        exp_q.push_back(rd_exp(a, model)); tag_q.push_back(t);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic do_rdwr(input logic [31:0] a, input logic [31:0] d, input string t);
        @(posedge clk); #1;
        addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b1;
        exp_q.push_back(rd_exp(a, model)); tag_q.push_back(t);
        model = apply(a, d, model);
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    // called right after a write task: lines update one edge later
    task automatic chk_lines(input string t);
        @(posedge clk); #1;
        checks++;
        if (rst_n !== lines(model)) begin
            errors++;
            $display("FAIL %s: rst_n %b expected %b", t, rst_n, lines(model));
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 checks++;
        if (rst_n !== 7'd0) begin
            errors++;
            $display("FAIL R1: rst_n %b expected 0000000 in reset", rst_n);
        end
        rst = 1'b0;
        chk_lines("R1");
        do_rd(BASE, "R1");

        do_wr(BASE, 32'h0000_0015);      chk_lines("R2 load 010101");
        do_rd(BASE + 4, "R6 read via alias1");
        do_wr(BASE, 32'hFFFF_FFC2);      chk_lines("R2 load 000010");
        do_rd(BASE + 8, "R6 upper bits read 0");

        do_wr(BASE + 4, 32'hFFFF_FF30);  chk_lines("R3 set 4,5");
        do_rd(BASE + 12, "R3 read via alias3");
        do_wr(BASE + 4, 32'h0000_0002);  chk_lines("R3 set already-set bit");

        do_wr(BASE + 8, 32'hFFFF_FF12);  chk_lines("R4 clear 1,4");
        do_rd(BASE, "R4");
        do_wr(BASE + 8, 32'h0000_0001);  chk_lines("R4 clear already-clear bit");

        do_wr(BASE + 12, 32'h0000_003F); chk_lines("R5 ignored alias");
        do_rd(BASE, "R5");

        do_wr(BASE, 32'h0000_0010);      chk_lines("R7 page-table line follows bit4");
        do_wr(BASE, 32'h0000_0020);      chk_lines("R7 bridge line follows bit5");

        do_rdwr(BASE + 8, 32'h0000_0020, "R8 read old on clear");
        chk_lines("R8");
        do_rdwr(BASE + 4, 32'h0000_003F, "R8 read old on set");
        do_rd(BASE, "R8 new value");

        do_wr(BASE + 16, 32'h0000_0000); chk_lines("R9 outside window");
        do_wr(BASE + 9, 32'h0000_0000);  chk_lines("R9 misaligned");
        do_rd(BASE + 16, "R9 read outside");
        do_rd(BASE + 1, "R9 read misaligned");

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule